// File: doc/BRIEF.md
# Selectable Clock Divider Bank with Grouped Outputs

This block takes one fast source clock and derives three slower clocks from it, arranged in two groups. Group A drives a single output. Group B drives two outputs that come from one shared divider, so they are always identical. Each group has a 2-bit select that picks one of four fixed division ratios. Each group also has an active-high enable. While a group is disabled, its outputs are held low.

An active-low bypass input makes every group pass the source clock through unchanged (divide by one), whatever its select says. The block clears all dividers on an asynchronous master reset and on a power-on reset. It releases them on one common source edge, so every group starts in phase. The output of every ratio is close to 50% high, including the odd ratio of five. That ratio uses a half-cycle copy taken on the falling edge of the source clock.

Top module: `clkdiv_bank`

## Requirements
- R1: The select code sets the output period in source cycles: 2'b00 gives 10, 2'b01 gives 2, 2'b10 gives 4, and 2'b11 gives 5.
- R2: While `bypass_n` is low, every group's output has the source period and follows the source clock, whatever the select inputs say.
- R3: While a group's enable is low, all outputs of that group stay at 0.
- R4: A change to a select or to bypass takes effect only where the current output period ends. No high or low pulse is ever shorter than half a source cycle.
- R5: `out_b0` and `out_b1` are equal at all times.
- R6: While `mreset` is high or `por_n` is low, all outputs are 0. After release on a falling source edge, every enabled dividing group gives its first rising edge on the third rising source edge, which is 2.5 source periods after the release.
- R7: For ratio N, the output stays high for N/2 source periods. For N = 5 this is 2.5 periods.
- R8: When an enable rises, the output resumes at the start of a low phase. Its first high pulse is a full N/2 periods long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_src | input | 1 | Source clock to be divided |
| por_n | input | 1 | Power-on reset, active low, asynchronous assert |
| mreset | input | 1 | Master reset, active high, asynchronous assert |
| bypass_n | input | 1 | Low forces divide by one on every group |
| sel_a | input | 2 | Ratio select, group A |
| sel_b | input | 2 | Ratio select, group B |
| oe_a | input | 1 | Output enable, group A |
| oe_b | input | 1 | Output enable, group B |
| out_a | output | 1 | Divided clock, group A |
| out_b0 | output | 1 | Divided clock, group B, first copy |
| out_b1 | output | 1 | Divided clock, group B, second copy |

## Verification
The hardest case to reach is a configuration change that lands at an awkward point: an enable, select or bypass edge that arrives partway through a high phase, or exactly on the edge where the block enters or leaves bypass. That is where a shortened pulse would appear. The stimulus holds a long run of randomly timed changes to selects, bypass and enables, applied at many offsets within the output periods. A monitor meanwhile measures every high and low width on both groups and counts any pulse shorter than half a source cycle. Directed measurements then time the period and high width for each ratio, in bypass, and for the first pulse after re-enable. They also time the first rising edges after each kind of reset.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int SEL_W   = 2;
  localparam int RATIO_W = 4;
  localparam int NGRP    = 2;
  localparam logic [RATIO_W-1:0] RATIO_RST = RATIO_W'(10);

  // Division ratio for a select code; bypass (active low) overrides to one.
  function automatic logic [RATIO_W-1:0] ratio_for(input logic [SEL_W-1:0] sel,
                                                   input logic byp_n);
    logic [RATIO_W-1:0] r;
    case (sel)
      2'b00:   r = RATIO_W'(10);
      2'b01:   r = RATIO_W'(2);
      2'b10:   r = RATIO_W'(4);
      default: r = RATIO_W'(5);
    endcase
    return byp_n ? r : RATIO_W'(1);
  endfunction

  // Count value below which the rising-edge phase register is high.
  function automatic logic [RATIO_W-1:0] high_span(input logic [RATIO_W-1:0] r);
    return r >> 1;
  endfunction

  // Count value at which the output is surely in its low phase.
  function automatic logic [RATIO_W-1:0] low_start(input logic [RATIO_W-1:0] r);
    return (r >> 1) + RATIO_W'(r[0]);
  endfunction
endpackage

// File: rtl/clkdiv_rst_sync.sv
module clkdiv_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst,
  output logic rst_o
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk or posedge arst) begin
    if (arst) sh <= '0;
    else      sh <= {sh[STAGES-2:0], 1'b1};
  end

  assign rst_o = ~sh[STAGES-1];
endmodule

// File: rtl/clkdiv_group.sv
module clkdiv_group
  import clkdiv_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [SEL_W-1:0]   sel,
  input  logic               byp_n,
  input  logic               oe,
  output logic               clk_out,
  output logic               wrap_o,
  output logic [RATIO_W-1:0] ratio_o,
  output logic [RATIO_W-1:0] cnt_o,
  output logic               phase_o,
  output logic               fresh_o,
  output logic               gate_o
);
  logic [RATIO_W-1:0] cnt, ratio, cnt_nxt, ratio_nxt;
  logic               fresh, ph_q, ph_n, en_q, en_n;
  logic               wrap, en_upd, is_byp, core;

  // Period boundary: last count of the period, or first edge out of reset.
  assign wrap      = fresh | (cnt == ratio - RATIO_W'(1));
  assign ratio_nxt = wrap ? ratio_for(sel, byp_n) : ratio;
  assign cnt_nxt   = wrap ? '0 : cnt + RATIO_W'(1);
  assign is_byp    = (ratio == RATIO_W'(1));
  assign en_upd    = fresh | is_byp | (cnt_nxt == low_start(ratio_nxt));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      cnt   <= '0;
      ratio <= RATIO_RST;
      fresh <= 1'b1;
      ph_q  <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      fresh <= 1'b0;
      cnt   <= cnt_nxt;
      ratio <= ratio_nxt;
      ph_q  <= (cnt_nxt < high_span(ratio_nxt));
      if (en_upd) en_q <= (is_byp && !fresh) ? en_n : oe;
    end
  end

  // Half-cycle copies taken while the source clock is high.
  always_ff @(negedge clk or posedge rst) begin
    if (rst) begin
      ph_n <= 1'b0;
      en_n <= 1'b0;
    end else begin
      ph_n <= ph_q;
      en_n <= oe;
    end
  end

  assign core    = ratio[0] ? (ph_q | ph_n) : ph_q;
  assign clk_out = ~rst & (is_byp ? (clk & en_n) : (core & en_q));

  assign wrap_o  = wrap;
  assign ratio_o = ratio;
  assign cnt_o   = cnt;
  assign phase_o = ph_q;
  assign fresh_o = fresh;
  assign gate_o  = en_q;
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_src,
  input  logic             por_n,
  input  logic             mreset,
  input  logic             bypass_n,
  input  logic [SEL_W-1:0] sel_a,
  input  logic [SEL_W-1:0] sel_b,
  input  logic             oe_a,
  input  logic             oe_b,
  output logic             out_a,
  output logic             out_b0,
  output logic             out_b1
);
  logic                            rst_sync;
  logic [NGRP-1:0][SEL_W-1:0]      sel_v;
  logic [NGRP-1:0]                 oe_v, grp_clk, grp_wrap, grp_phase, grp_fresh, grp_gate;
  logic [NGRP-1:0][RATIO_W-1:0]    grp_ratio, grp_cnt;

  clkdiv_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk  (clk_src),
    .arst (mreset | ~por_n),
    .rst_o(rst_sync)
  );

  assign sel_v = {sel_b, sel_a};
  assign oe_v  = {oe_b, oe_a};

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    clkdiv_group u_grp (
      .clk    (clk_src),
      .rst    (rst_sync),
      .sel    (sel_v[g]),
      .byp_n  (bypass_n),
      .oe     (oe_v[g]),
      .clk_out(grp_clk[g]),
      .wrap_o (grp_wrap[g]),
      .ratio_o(grp_ratio[g]),
      .cnt_o  (grp_cnt[g]),
      .phase_o(grp_phase[g]),
      .fresh_o(grp_fresh[g]),
      .gate_o (grp_gate[g])
    );
  end

  assign out_a  = grp_clk[0];
  assign out_b0 = grp_clk[1];
  assign out_b1 = grp_clk[1];
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
(
  input logic                         clk,
  input logic                         rst,
  input logic                         bypass_n,
  input logic [NGRP-1:0]              wrap,
  input logic [NGRP-1:0][RATIO_W-1:0] ratio,
  input logic [NGRP-1:0][RATIO_W-1:0] cnt,
  input logic [NGRP-1:0]              phase,
  input logic [NGRP-1:0]              fresh,
  input logic [NGRP-1:0]              gate,
  input logic [NGRP-1:0]              outs,
  input logic                         out_b0,
  input logic                         out_b1
);
  for (genvar g = 0; g < NGRP; g++) begin : g_chk
    // R1: the count stays inside the selected period
    p_cnt_range_r1: assert property (@(posedge clk) disable iff (rst)
      cnt[g] < ratio[g]);
    // R4: the ratio only moves at a period boundary
    p_ratio_steady_r4: assert property (@(posedge clk) disable iff (rst)
      !wrap[g] |=> $stable(ratio[g]));
    // R2: a boundary seen in bypass loads divide by one
    p_bypass_one_r2: assert property (@(posedge clk) disable iff (rst)
      (wrap[g] && !bypass_n) |=> (ratio[g] == RATIO_W'(1)));
    // R3: a closed gate keeps a dividing output low
    p_gate_low_r3: assert property (@(posedge clk) disable iff (rst)
      (!gate[g] && ratio[g] != RATIO_W'(1)) |-> !outs[g]);
  end

  // R5: both group-B copies agree
  p_twins_r5: assert property (@(posedge clk) disable iff (rst)
    out_b0 == out_b1);
  // R6: all dividing groups raise their phase on the first edge out of reset
  p_joint_start_r6: assert property (@(posedge clk) disable iff (rst)
    (fresh[0] && bypass_n) |=> (phase[0] && phase[1]));
endmodule

bind clkdiv_bank clkdiv_bank_chk u_chk (
  .clk     (clk_src),
  .rst     (rst_sync),
  .bypass_n(bypass_n),
  .wrap    (grp_wrap),
  .ratio   (grp_ratio),
  .cnt     (grp_cnt),
  .phase   (grp_phase),
  .fresh   (grp_fresh),
  .gate    (grp_gate),
  .outs    (grp_clk),
  .out_b0  (out_b0),
  .out_b1  (out_b1)
);

// File: tb/test_clkdiv_bank.sv
module test_clkdiv_bank;
  localparam int CLK_PERIOD = 10;
  localparam int SYNC       = 2;

  logic clk = 1'b0;
  logic por_n = 1'b0, mreset = 1'b1, bypass_n = 1'b1, oe_a = 1'b1, oe_b = 1'b1;
  logic [1:0] sel_a = 2'b00, sel_b = 2'b00;
  logic out_a, out_b0, out_b1;

  int n_chk = 0, n_fail = 0;
  int runts = 0, twin_bad = 0;
  logic mon = 1'b0;
  time ra = 0, fa = 0, rb = 0, fb = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clkdiv_bank #(.SYNC_STAGES(SYNC)) i_clkdiv_bank (
    .clk_src(clk), .por_n(por_n), .mreset(mreset), .bypass_n(bypass_n),
    .sel_a(sel_a), .sel_b(sel_b), .oe_a(oe_a), .oe_b(oe_b),
    .out_a(out_a), .out_b0(out_b0), .out_b1(out_b1)
  );

  function automatic int exp_div(input logic [1:0] s, input logic byp_n);
    if (!byp_n) return 1;
    case (s)
      2'b00: return 10;
      2'b01: return 2;
      2'b10: return 4;
      default: return 5;
    endcase
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  // Pulse width monitor for R4 (no runt pulses).
  always @(posedge out_a) begin
    if (mon && ($time - fa) < CLK_PERIOD/2) runts++;
    ra = $time;
  end
  always @(negedge out_a) begin
    if (mon && ($time - ra) < CLK_PERIOD/2) runts++;
    fa = $time;
  end
  always @(posedge out_b0) begin
    if (mon && ($time - fb) < CLK_PERIOD/2) runts++;
    rb = $time;
  end
  always @(negedge out_b0) begin
    if (mon && ($time - rb) < CLK_PERIOD/2) runts++;
    fb = $time;
  end
  // R5 twin comparison, sampled away from the source edges
  always @(clk) begin
    #2;
    if (out_b0 !== out_b1) twin_bad++;
  end

  task automatic meas(input int g, input int n, input string tag);
    time t0, t1, t2;
    if (g == 0) begin
      @(posedge out_a); t0 = $time; @(negedge out_a); t1 = $time; @(posedge out_a); t2 = $time;
    end else begin
      @(posedge out_b0); t0 = $time; @(negedge out_b0); t1 = $time; @(posedge out_b0); t2 = $time;
    end
    check(tag, "period", int'(t2 - t0), n * CLK_PERIOD);
    check(tag, "high time", int'(t1 - t0), n * CLK_PERIOD / 2);
  endtask

  task automatic settle;
    @(posedge clk); #2;
  endtask

  task automatic align(input string which);
    time tr, ta, tb;
    @(negedge clk);
    if (which == "mr") mreset = 1'b0; else por_n = 1'b1;
    tr = $time;
    fork
      begin @(posedge out_a); ta = $time; end
      begin @(posedge out_b0); tb = $time; end
    join
    // R6: first rise on the third source rising edge after release
    check("R6", "group A first rise delay", int'(ta - tr), SYNC * CLK_PERIOD + CLK_PERIOD/2);
    check("R6", "group B first rise delay", int'(tb - tr), SYNC * CLK_PERIOD + CLK_PERIOD/2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    int highs;
    logic [1:0] sb;
    void'($urandom(32'd7215));

    // R6: outputs low under reset
    highs = 0;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); #1;
      if (out_a | out_b0 | out_b1) highs++;
    end
    check("R6", "highs during power-on reset", highs, 0);
    por_n = 1'b1;
    repeat (2) @(posedge clk);
    sel_a = 2'b11; sel_b = 2'b00;
    align("mr");

    // R1 / R7: every ratio on both groups
    for (int s = 0; s < 4; s++) begin
      settle();
      sel_a = 2'(s);
      sb = 2'($urandom);
      sel_b = sb;
      repeat (25) @(posedge clk);
      meas(0, exp_div(2'(s), 1'b1), "R1 R7 group A");
      meas(1, exp_div(sb, 1'b1), "R1 R7 group B");
    end
    settle(); sel_b = 2'b11;
    repeat (25) @(posedge clk);
    meas(1, 5, "R7 odd ratio group B");

    // R2: bypass overrides selects
    settle(); bypass_n = 1'b0;
    repeat (25) @(posedge clk);
    meas(0, 1, "R2 group A");
    meas(1, 1, "R2 group B");
    settle(); bypass_n = 1'b1;
    repeat (25) @(posedge clk);

    // R3: disabled group stays low
    settle(); oe_b = 1'b0;
    repeat (25) @(posedge clk);
    highs = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk); #1;
      if (out_b0 | out_b1) highs++;
      @(posedge clk); #1;
      if (out_b0 | out_b1) highs++;
    end
    check("R3", "group B highs while disabled", highs, 0);
    // R8: re-enable gives a full first pulse (ratio 5)
    @(negedge clk); #1; oe_b = 1'b1;
    meas(1, 5, "R8 re-enable ratio 5");
    settle(); oe_a = 1'b0; sel_a = 2'b10;
    repeat (30) @(posedge clk);
    @(posedge clk); #7; oe_a = 1'b1;
    meas(0, 4, "R8 re-enable ratio 4");

    // R4 / R5: randomly timed reconfiguration
    repeat (30) @(posedge clk);
    mon = 1'b1;
    for (int i = 0; i < 60; i++) begin
      @(posedge clk);
      #(1 + ($urandom % 8));
      case ($urandom % 4)
        0: sel_a = 2'($urandom);
        1: sel_b = 2'($urandom);
        2: bypass_n = ($urandom % 3) != 0;
        default: begin oe_a = ($urandom % 4) != 0; oe_b = ($urandom % 4) != 0; end
      endcase
      repeat (1 + $urandom % 25) @(posedge clk);
    end
    mon = 1'b0;
    check("R4", "runt pulses", runts, 0);
    check("R5", "group B copy mismatches", twin_bad, 0);

    // R1: final random configuration measured
    settle();
    oe_a = 1'b1; oe_b = 1'b1; bypass_n = 1'b1;
    sel_a = 2'($urandom); sel_b = 2'($urandom);
    repeat (25) @(posedge clk);
    meas(0, exp_div(sel_a, bypass_n), "R1 random group A");
    meas(1, exp_div(sel_b, bypass_n), "R1 random group B");

    // R6: power-on reset mid-run, then aligned restart
    sel_a = 2'b11; sel_b = 2'b00;
    @(posedge clk); #3; por_n = 1'b0;
    #1;
    check("R6", "group A right after reset", int'(out_a), 0);
    check("R6", "group B right after reset", int'(out_b0 | out_b1), 0);
    repeat (3) @(posedge clk);
    align("por");

    summary();
    $finish;
  end
endmodule